// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block collects the interrupt conditions of a 16550-style serial port and turns them into a single interrupt request line and a 4-bit identification code for the CPU. The five causes are receive line errors, receive data ready, receive character time-out, transmitter holding empty and modem line change. When several are pending, a fixed priority picks one. Each cause also has its own clearing access, which the surrounding register file signals to this block as one-cycle strobes.

The transmit-empty cause has special gating. If the transmit FIFO drains after holding at least two characters at once, the cause is raised immediately. Otherwise, including the first empty state after reset, it is held back by `CHAR_BITS` bit-time ticks. This gives software time to refill the FIFO before an interrupt arrives. An identification read clears this cause only when it is the code being reported. The reported code is captured into `id_latched` at the read.

Top module: `uart_irq_ident`

## Requirements
- R1: With no enabled cause pending, `id_code` is 0001 and `irq` is low. Whenever `id_code` bit 0 is 0, `irq` is high.
- R2: Among enabled pending causes, `id_code` reports them in this order, highest first: line error 0110, receive data 0100, time-out 1100, transmit empty 0010, modem 0000.
- R3: Any set bit of `lsr_evt` makes the line cause pending from the next clock. Only `lsr_rd` clears it.
- R4: The receive data cause is a registered copy of the receive condition, so it follows that condition one clock later. With `fifo_en` high, the condition is `rx_level >= trig_level`. With `fifo_en` low, the condition is `rx_level != 0`.
- R5: A pulse on `tmo_evt` makes the time-out cause pending. `rbr_rd` clears it.
- R6: When `tx_count` returns to 0, and it has been 2 or more since the last time it returned to 0, the transmit-empty cause is pending from the next clock.
- R7: When `tx_count` returns to 0 otherwise, the transmit-empty cause becomes pending on the clock that samples the `CHAR_BITS`-th high `bit_tick`. The count is cancelled if `tx_count` becomes non-zero first. The first clock after reset counts as a return to 0.
- R8: `thr_wr` clears the transmit-empty cause, and it takes precedence over any set. `iir_rd` clears this cause only when `id_code` is 0010 during the read.
- R9: A change on `cts`, `dsr` or `dcd`, or a rising edge on `ri`, makes the modem cause pending. A falling edge on `ri` does not. Changes are detected from the second clock after reset. `msr_rd` clears the cause.
- R10: On `iir_rd`, `id_latched` takes the value that `id_code` has in that cycle; its reset value is 0001. A cause that is set in the same cycle as its clearing access stays pending.
- R11: The `ier` bits mask causes without altering their pending state: bit 0 masks receive data and time-out, bit 1 masks transmit empty, bit 2 masks line error, and bit 3 masks modem.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ier | input | 4 | Per-cause enable bits |
| lsr_evt | input | 4 | Overrun, parity, framing and break error pulses |
| fifo_en | input | 1 | Receive FIFO mode selects trigger compare |
| rx_level | input | CNT_W | Receive FIFO fill level |
| trig_level | input | CNT_W | Receive trigger level |
| tmo_evt | input | 1 | Character time-out pulse |
| tx_count | input | CNT_W | Transmit FIFO fill level |
| bit_tick | input | 1 | One pulse per serial bit time |
| cts | input | 1 | Clear-to-send line, synchronised |
| dsr | input | 1 | Data-set-ready line, synchronised |
| dcd | input | 1 | Carrier-detect line, synchronised |
| ri | input | 1 | Ring-indicator line, synchronised |
| lsr_rd | input | 1 | Line status register read strobe |
| rbr_rd | input | 1 | Receive buffer read strobe |
| thr_wr | input | 1 | Transmit holding register write strobe |
| iir_rd | input | 1 | Identification register read strobe |
| msr_rd | input | 1 | Modem status register read strobe |
| irq | output | 1 | Interrupt request, active high |
| id_code | output | 4 | Current identification code |
| id_latched | output | 4 | Code captured at the last identification read |

## Verification
Every pending cause is registered, so a stimulus that the rising edge samples shows up in `id_code` and `irq` right after that edge, and a clearing strobe takes effect at the same edge. `ier` is the exception: it acts combinationally, without waiting for a clock. The delayed transmit-empty cause appears exactly on the clock that samples the `CHAR_BITS`-th tick. The bench drives every input on the falling edge, and a bench model advances on the rising edge. The bench compares all outputs against that model at the following falling edge, before it changes any input, so each comparison sees results exactly one edge after their cause.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef enum logic [3:0] {
        IID_NONE = 4'b0001,
        IID_LINE = 4'b0110,
        IID_RXD  = 4'b0100,
        IID_TMO  = 4'b1100,
        IID_THRE = 4'b0010,
        IID_MDM  = 4'b0000
    } iid_e;

    localparam int EN_RX = 0;
    localparam int EN_TX = 1;
    localparam int EN_LS = 2;
    localparam int EN_MS = 3;

    localparam int MDM_LINES = 4;
    localparam int RI_BIT    = 3;

endpackage

// File: rtl/uart_irq_sticky.sv
module uart_irq_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);
    logic pend_d, pend_q;

    // a new event in the clearing cycle is kept
    always_comb begin
        pend_d = set_i | (pend_q & ~clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/uart_irq_thre.sv
module uart_irq_thre #(
    parameter int CNT_W     = 5,
    parameter int CHAR_BITS = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tx_count,
    input  logic             bit_tick,
    input  logic             thr_wr,
    input  logic             rd_clear,
    output logic             pend_o
);
    localparam int DLY_W = $clog2(CHAR_BITS + 1);

    typedef struct packed {
        logic             emp;
        logic             held;
        logic             act;
        logic [DLY_W-1:0] cnt;
        logic             pend;
    } thre_s;

    thre_s st_d, st_q;
    logic  empty;
    logic  set_now;

    always_comb begin
        st_d    = st_q;
        empty   = (tx_count == '0);
        set_now = 1'b0;

        if (tx_count >= CNT_W'(2)) st_d.held = 1'b1;

        if (empty && !st_q.emp) begin
            st_d.held = 1'b0;
            if (st_q.held) begin
                set_now = 1'b1;
            end else begin
                st_d.act = 1'b1;
                st_d.cnt = DLY_W'(CHAR_BITS);
            end
        end else if (st_q.act) begin
            if (!empty) begin
                st_d.act = 1'b0;
            end else if (bit_tick) begin
                if (st_q.cnt <= DLY_W'(1)) begin
                    st_d.act = 1'b0;
                    set_now  = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - DLY_W'(1);
                end
            end
        end

        st_d.emp  = empty;
        st_d.pend = ((st_q.pend & ~rd_clear) | set_now) & ~thr_wr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
endmodule

// File: rtl/uart_irq_modem.sv
module uart_irq_modem
    import uart_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [MDM_LINES-1:0] lines,
    input  logic                 msr_rd,
    output logic                 pend_o
);
    typedef struct packed {
        logic [MDM_LINES-1:0] prev;
        logic                 primed;
        logic                 pend;
    } mdm_s;

    mdm_s                 st_d, st_q;
    logic [MDM_LINES-1:0] hit;

    always_comb begin
        for (int i = 0; i < MDM_LINES; i++) begin
            if (i == RI_BIT) hit[i] = lines[i] & ~st_q.prev[i];
            else             hit[i] = lines[i] ^ st_q.prev[i];
        end
        st_d        = st_q;
        st_d.prev   = lines;
        st_d.primed = 1'b1;
        st_d.pend   = (st_q.primed & (|hit)) | (st_q.pend & ~msr_rd);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int CNT_W     = 5,
    parameter int CHAR_BITS = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       ier,
    input  logic [3:0]       lsr_evt,
    input  logic             fifo_en,
    input  logic [CNT_W-1:0] rx_level,
    input  logic [CNT_W-1:0] trig_level,
    input  logic             tmo_evt,
    input  logic [CNT_W-1:0] tx_count,
    input  logic             bit_tick,
    input  logic             cts,
    input  logic             dsr,
    input  logic             dcd,
    input  logic             ri,
    input  logic             lsr_rd,
    input  logic             rbr_rd,
    input  logic             thr_wr,
    input  logic             iir_rd,
    input  logic             msr_rd,
    output logic             irq,
    output logic [3:0]       id_code,
    output logic [3:0]       id_latched
);
    typedef struct packed {
        logic       rda;
        logic [3:0] iid_rd;
    } top_s;

    top_s st_d, st_q;
    iid_e code;
    logic ls_pend, tmo_pend, thre_pend, mdm_pend;
    logic rx_cond;

    uart_irq_sticky u_line (
        .clk(clk), .rst_n(rst_n), .set_i(|lsr_evt), .clr_i(lsr_rd), .pend_o(ls_pend)
    );

    uart_irq_sticky u_tmo (
        .clk(clk), .rst_n(rst_n), .set_i(tmo_evt), .clr_i(rbr_rd), .pend_o(tmo_pend)
    );

    uart_irq_thre #(.CNT_W(CNT_W), .CHAR_BITS(CHAR_BITS)) u_thre (
        .clk(clk), .rst_n(rst_n), .tx_count(tx_count), .bit_tick(bit_tick),
        .thr_wr(thr_wr), .rd_clear(iir_rd && (code == IID_THRE)), .pend_o(thre_pend)
    );

    uart_irq_modem u_mdm (
        .clk(clk), .rst_n(rst_n), .lines({ri, dcd, dsr, cts}),
        .msr_rd(msr_rd), .pend_o(mdm_pend)
    );

    always_comb begin
        rx_cond = fifo_en ? (rx_level >= trig_level) : (rx_level != '0);

        if      (ls_pend   && ier[EN_LS]) code = IID_LINE;
        else if (st_q.rda  && ier[EN_RX]) code = IID_RXD;
        else if (tmo_pend  && ier[EN_RX]) code = IID_TMO;
        else if (thre_pend && ier[EN_TX]) code = IID_THRE;
        else if (mdm_pend  && ier[EN_MS]) code = IID_MDM;
        else                              code = IID_NONE;

        st_d     = st_q;
        st_d.rda = rx_cond;
        if (iir_rd) st_d.iid_rd = code;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{rda: 1'b0, iid_rd: IID_NONE};
        else        st_q <= st_d;
    end

    assign id_code    = code;
    assign irq        = ~code[0];
    assign id_latched = st_q.iid_rd;
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] ier,
    input logic [3:0] lsr_evt,
    input logic       thr_wr,
    input logic       iir_rd,
    input logic       irq,
    input logic [3:0] id_code,
    input logic [3:0] id_latched
);
    AST_NONE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        id_code[0] |-> (id_code == 4'b0001 && !irq)); // R1

    AST_LINE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ((|lsr_evt) && ier[2]) |=> (!ier[2] || id_code == 4'b0110)); // R3

    AST_THR_WR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr |=> (id_code != 4'b0010)); // R8

    AST_RD_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        iir_rd |=> (id_latched == $past(id_code))); // R10

    AST_MASK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (ier == 4'b0000) |-> (!irq && id_code == 4'b0001)); // R11
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ier(ier), .lsr_evt(lsr_evt), .thr_wr(thr_wr),
    .iir_rd(iir_rd), .irq(irq), .id_code(id_code), .id_latched(id_latched)
);

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;
    localparam int CNT_W = 5;
    localparam int CB    = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] ier = 4'h0, lsr_evt = 4'h0;
    logic fifo_en = 1'b0, tmo_evt = 1'b0, bit_tick = 1'b0;
    logic [CNT_W-1:0] rx_level = '0, trig_level = '0, tx_count = '0;
    logic cts = 1'b0, dsr = 1'b0, dcd = 1'b0, ri = 1'b0;
    logic lsr_rd = 1'b0, rbr_rd = 1'b0, thr_wr = 1'b0, iir_rd = 1'b0, msr_rd = 1'b0;
    logic irq;
    logic [3:0] id_code, id_latched;

    int n_chk = 0, n_bad = 0, cyc = 0;

    always #5 clk = ~clk;

    uart_irq_ident #(.CNT_W(CNT_W), .CHAR_BITS(CB)) u_dut (
        .clk(clk), .rst_n(rst_n), .ier(ier), .lsr_evt(lsr_evt), .fifo_en(fifo_en),
        .rx_level(rx_level), .trig_level(trig_level), .tmo_evt(tmo_evt),
        .tx_count(tx_count), .bit_tick(bit_tick), .cts(cts), .dsr(dsr), .dcd(dcd),
        .ri(ri), .lsr_rd(lsr_rd), .rbr_rd(rbr_rd), .thr_wr(thr_wr), .iir_rd(iir_rd),
        .msr_rd(msr_rd), .irq(irq), .id_code(id_code), .id_latched(id_latched)
    );

    // bench model, written from the requirements
    logic m_ls, m_rda, m_tmo, m_thre, m_mdm, m_prim, m_emp, m_held, m_act;
    int   m_cnt;
    logic [3:0] m_prev, m_lat;

    function automatic logic [3:0] mcode(logic ls, logic rda, logic tmo, logic th,
                                          logic md, logic [3:0] en);
        if (ls && en[2])  return 4'b0110;
        if (rda && en[0]) return 4'b0100;
        if (tmo && en[0]) return 4'b1100;
        if (th && en[1])  return 4'b0010;
        if (md && en[3])  return 4'b0000;
        return 4'b0001;
    endfunction

    function automatic string tag_of(logic [3:0] c);
        case (c)
            4'b0110: return "R3";
            4'b0100: return "R4";
            4'b1100: return "R5";
            4'b0010: return "R6";
            4'b0000: return "R9";
            default: return "R1";
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ls <= 0; m_rda <= 0; m_tmo <= 0; m_thre <= 0; m_mdm <= 0; m_prim <= 0;
            m_emp <= 0; m_held <= 0; m_act <= 0; m_cnt <= 0; m_prev <= 0; m_lat <= 4'b0001;
        end else begin
            logic [3:0] cur, now;
            logic fire;
            cur  = {ri, dcd, dsr, cts};
            now  = mcode(m_ls, m_rda, m_tmo, m_thre, m_mdm, ier);
            fire = 1'b0;
            m_ls  <= (|lsr_evt) || (m_ls && !lsr_rd);
            m_tmo <= tmo_evt || (m_tmo && !rbr_rd);
            m_rda <= fifo_en ? (rx_level >= trig_level) : (rx_level != 0);
            m_mdm <= (m_prim && ((cur[2:0] != m_prev[2:0]) || (cur[3] && !m_prev[3])))
                     || (m_mdm && !msr_rd);
            m_prev <= cur;
            m_prim <= 1'b1;
            if (iir_rd) m_lat <= now;
            m_emp <= (tx_count == 0);
            if (tx_count >= 2) m_held <= 1'b1;
            if (tx_count == 0 && !m_emp) begin
                m_held <= 1'b0;
                if (m_held) fire = 1'b1;
                else begin m_act <= 1'b1; m_cnt <= CB; end
            end else if (m_act) begin
                if (tx_count != 0) m_act <= 1'b0;
                else if (bit_tick) begin
                    if (m_cnt == 1) begin m_act <= 1'b0; fire = 1'b1; end
                    else m_cnt <= m_cnt - 1;
                end
            end
            if (thr_wr) m_thre <= 1'b0;
            else if (fire) m_thre <= 1'b1;
            else if (iir_rd && now == 4'b0010) m_thre <= 1'b0;
        end
    end

    task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic cmp_model();
        logic [3:0] e;
        e = mcode(m_ls, m_rda, m_tmo, m_thre, m_mdm, ier);
        chk(tag_of(e), id_code, e);
        chk("R1 irq", {3'b0, irq}, {3'b0, ~e[0]});
        chk("R10 latched", id_latched, m_lat);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        cmp_model();
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected<=100000", cyc);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        ier = 4'b0010;
        repeat (2) @(negedge clk);
        chk("R1 reset code", id_code, 4'b0001);
        chk("R1 reset irq", {3'b0, irq}, 4'b0);
        chk("R10 reset latch", id_latched, 4'b0001);
        rst_n = 1'b1;
        step();
        // R7: start-up delay of CB ticks
        for (int i = 0; i < CB - 1; i++) begin
            bit_tick = 1'b1; step();
        end
        chk("R7 before last tick", id_code, 4'b0001);
        step(); // bit_tick still high: final tick
        bit_tick = 1'b0;
        chk("R7 after last tick", id_code, 4'b0010);
        // R8: identification read clears reported THRE
        iir_rd = 1'b1; step(); iir_rd = 1'b0;
        chk("R8 iir clear", id_code, 4'b0001);
        chk("R10 latched thre", id_latched, 4'b0010);
        // R6: held two, immediate
        tx_count = 1; step(); tx_count = 2; step(); tx_count = 0; step();
        chk("R6 immediate", id_code, 4'b0010);
        thr_wr = 1'b1; tx_count = 1; step(); thr_wr = 1'b0;
        chk("R8 write clear", id_code, 4'b0001);
        tx_count = 0; step();
        chk("R7 delayed again", id_code, 4'b0001);
        bit_tick = 1'b1;
        for (int i = 0; i < CB; i++) step();
        bit_tick = 1'b0;
        chk("R7 delay done", id_code, 4'b0010);
        // R11: mask keeps pending
        ier = 4'b0000; #1;
        chk("R11 masked", id_code, 4'b0001);
        ier = 4'b0010; #1;
        chk("R11 unmasked", id_code, 4'b0010);
        // R2: priority walk
        ier = 4'hF; lsr_evt = 4'b0001; cts = 1'b1; step(); lsr_evt = 4'b0;
        chk("R2 line top", id_code, 4'b0110);
        lsr_rd = 1'b1; step(); lsr_rd = 1'b0;
        chk("R2 thre over modem", id_code, 4'b0010);
        iir_rd = 1'b1; step(); iir_rd = 1'b0;
        chk("R2 modem last", id_code, 4'b0000);
        msr_rd = 1'b1; step(); msr_rd = 1'b0;
        chk("R9 msr clear", id_code, 4'b0001);
        // R10: event during read retained
        cts = 1'b0; step();
        iir_rd = 1'b1; lsr_evt = 4'b1000; step(); iir_rd = 1'b0; lsr_evt = 4'b0;
        chk("R10 latched modem", id_latched, 4'b0000);
        chk("R10 new line kept", id_code, 4'b0110);
        lsr_rd = 1'b1; step(); lsr_rd = 1'b0;
        msr_rd = 1'b1; step(); msr_rd = 1'b0;
        // R9: ri falling edge ignored
        ri = 1'b1; step();
        chk("R9 ri rise", id_code, 4'b0000);
        msr_rd = 1'b1; step(); msr_rd = 1'b0;
        ri = 1'b0; step();
        chk("R9 ri fall", id_code, 4'b0001);
        // R4 / R5
        fifo_en = 1'b1; trig_level = 4; rx_level = 3; step();
        chk("R4 below trig", id_code, 4'b0001);
        rx_level = 4; step();
        chk("R4 at trig", id_code, 4'b0100);
        fifo_en = 1'b0; rx_level = 0; step();
        chk("R4 empty", id_code, 4'b0001);
        tmo_evt = 1'b1; step(); tmo_evt = 1'b0;
        chk("R5 timeout", id_code, 4'b1100);
        rx_level = 2; step();
        chk("R2 rxd over timeout", id_code, 4'b0100);
        rbr_rd = 1'b1; rx_level = 0; step(); rbr_rd = 1'b0;
        chk("R5 rbr clear", id_code, 4'b0001);
        // random phase
        for (int k = 0; k < 4000; k++) begin
            int r;
            r = $urandom % 100;
            lsr_evt  = (r < 4) ? 4'($urandom) : 4'b0;
            lsr_rd   = ($urandom % 10) == 0;
            rbr_rd   = ($urandom % 10) == 0;
            thr_wr   = ($urandom % 12) == 0;
            iir_rd   = ($urandom % 6) == 0;
            msr_rd   = ($urandom % 10) == 0;
            tmo_evt  = ($urandom % 25) == 0;
            bit_tick = ($urandom % 3) == 0;
            fifo_en  = ($urandom % 4) != 0;
            rx_level = CNT_W'($urandom % 6);
            trig_level = CNT_W'($urandom % 5);
            if (($urandom % 4) == 0) begin
                if (($urandom % 2) == 0 && tx_count != 0) tx_count = tx_count - 1;
                else if (tx_count < 4) tx_count = tx_count + 1;
            end
            if (($urandom % 20) == 0) {ri, dcd, dsr, cts} = 4'($urandom);
            if (($urandom % 20) == 0) ier = 4'($urandom);
            else if (($urandom % 10) == 0) ier = 4'hF;
            step();
        end
        finish_run();
    end
endmodule